// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block is the decision core of an eight-line interrupt controller. On every cycle it looks at the pending request lines, the mask, the in-service set and a rotation offset. From these it decides whether the interrupt output should be raised and which line wins. The request lines reach it already captured. The mask and the mode flags are held by a register front end outside the block.

The block owns two pieces of state: the in-service set and the rotation offset. The processor side changes them in two ways. An acknowledge strobe takes the current winner. A one-cycle command strobe carries an end-of-interrupt or priority command, with a 3-bit operation code and a line number.

The priority order is circular and starts at the line named by the offset. This gives fixed priority when the offset stays at zero and round-robin service when the offset is advanced.

All pins are plain control and status signals, and none of them uses a valid/ready exchange. The winner pair (`win_valid_o`, `win_line_o`) is a level that follows the registered state. The acknowledge and command strobes are accepted in the cycle they are high, so the block never applies back-pressure.

Top module: `irq_prio_resolver`

## Requirements
- R1: Priority rank p (0 = best) belongs to line (offset + p) mod 8. `win_line_o` is the pending unmasked line with the smallest rank.
- R2: `int_o` and `win_valid_o` are high exactly when some line is pending and unmasked (`req_i & ~mask_i`) and its best rank is strictly smaller than the best rank among the in-service lines being considered. If no in-service line is considered, that rank counts as 8.
- R3: While `special_mask_i` is high, in-service lines that are masked are left out of the in-service rank.
- R4: While both `master_i` and `sfnm_i` are high, in-service line 2 is left out of the in-service rank.
- R5: An acknowledge (`ack_i`) while `int_o` is high and `auto_eoi_i` is low sets the winner's in-service bit. An acknowledge while `int_o` is low changes nothing.
- R6: An acknowledge while `int_o` is high and `auto_eoi_i` is high leaves the in-service set unchanged. If `rot_aeoi_i` is also high, the offset becomes (winner + 1) mod 8.
- R7: Operation code 0 clears the in-service bit with the best rank. Code 1 does the same and also sets the offset to (that line + 1) mod 8. When the in-service set is empty, both codes leave all state unchanged.
- R8: Code 2 clears the in-service bit of `cmd_line_i`. Code 3 clears that bit and sets the offset to (`cmd_line_i` + 1) mod 8. Code 4 sets the offset to (`cmd_line_i` + 1) mod 8. Codes 5, 6 and 7 have no effect.
- R9: If a command strobe and an acknowledge occur in the same cycle, only the command takes effect.
- R10: After reset the in-service set and the offset are zero, and the interrupt output depends only on the pending unmasked requests.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 8 | Captured request lines |
| mask_i | input | 8 | Mask, 1 = line masked |
| auto_eoi_i | input | 1 | Acknowledge does not enter the in-service set |
| rot_aeoi_i | input | 1 | Rotate the offset on an automatic end of interrupt |
| special_mask_i | input | 1 | Leave masked in-service lines out of the rank |
| sfnm_i | input | 1 | Nested mode that leaves out the cascade line |
| master_i | input | 1 | This controller is the cascade master |
| ack_i | input | 1 | Acknowledge strobe |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 3 | Operation code (see R7, R8) |
| cmd_line_i | input | 3 | Line operand of the command |
| int_o | output | 1 | Interrupt request output |
| win_valid_o | output | 1 | `win_line_o` holds a winner |
| win_line_o | output | 3 | Winning line |
| isr_o | output | 8 | In-service set |
| offset_o | output | 3 | Rotation offset |

## Verification
The bench builds the block with its defaults: eight lines, cascade on line 2. At this size every offset can be paired with every one of the 256 request patterns, and every mask pattern can be swept against full requests, all with arithmetic expectations. A long random phase then drives modes, acknowledges and all eight operation codes against a small bench-side model of the in-service set and the offset. This covers the nesting, special mask, cascade exclusion and rotation interactions that the sweeps alone do not reach.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;

  // command operation codes
  localparam logic [2:0] OP_EOI_NS       = 3'd0;
  localparam logic [2:0] OP_EOI_NS_ROT   = 3'd1;
  localparam logic [2:0] OP_EOI_SPEC     = 3'd2;
  localparam logic [2:0] OP_EOI_SPEC_ROT = 3'd3;
  localparam logic [2:0] OP_SET_PRIO     = 3'd4;

  // (a + b) mod lines
  function automatic int unsigned wrap_add(input int unsigned a,
                                           input int unsigned b,
                                           input int unsigned lines);
    return (a + b) % lines;
  endfunction

endpackage

// File: rtl/irq_prio_search.sv
module irq_prio_search #(
  parameter int LINES = 8,
  parameter int LW    = $clog2(LINES)
) (
  input  logic [LINES-1:0] vec_i,
  input  logic [LW-1:0]    base_i,
  output logic [LW:0]      prio_o
);

  logic [2*LINES-1:0] dbl;
  logic [LINES-1:0]   rot;

  // rot[p] is the line that holds rank p
  assign dbl = {vec_i, vec_i} >> base_i;
  assign rot = dbl[LINES-1:0];

  always_comb begin
    prio_o = (LW+1)'(LINES);
    for (int p = LINES - 1; p >= 0; p--) begin
      if (rot[p]) prio_o = (LW+1)'(p);
    end
  end

endmodule

// File: rtl/irq_state_ctrl.sv
module irq_state_ctrl
  import irq_res_pkg::*;
#(
  parameter int LINES = 8,
  parameter int LW    = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ack_i,
  input  logic             grant_i,
  input  logic [LW-1:0]    win_line_i,
  input  logic             auto_eoi_i,
  input  logic             rot_aeoi_i,
  input  logic             cmd_valid_i,
  input  logic [2:0]       cmd_op_i,
  input  logic [LW-1:0]    cmd_line_i,
  input  logic [LW:0]      top_prio_i,
  output logic [LINES-1:0] isr_o,
  output logic [LW-1:0]    offset_o
);

  logic [LINES-1:0] isr_q, isr_d;
  logic [LW-1:0]    off_q, off_d;
  logic [LW-1:0]    top_line;
  logic             isr_empty;

  function automatic logic [LW-1:0] succ(input logic [LW-1:0] l);
    return LW'(wrap_add(int'(l), 1, LINES));
  endfunction

  assign isr_empty = (top_prio_i == (LW+1)'(LINES));
  assign top_line  = LW'(wrap_add(int'(top_prio_i[LW-1:0]), int'(off_q), LINES));

  always_comb begin
    isr_d = isr_q;
    off_d = off_q;
    if (cmd_valid_i) begin
      case (cmd_op_i)
        OP_EOI_NS, OP_EOI_NS_ROT: begin
          if (!isr_empty) begin
            isr_d[top_line] = 1'b0;
            if (cmd_op_i == OP_EOI_NS_ROT) off_d = succ(top_line);
          end
        end
        OP_EOI_SPEC: isr_d[cmd_line_i] = 1'b0;
        OP_EOI_SPEC_ROT: begin
          isr_d[cmd_line_i] = 1'b0;
          off_d = succ(cmd_line_i);
        end
        OP_SET_PRIO: off_d = succ(cmd_line_i);
        default: ;
      endcase
    end else if (ack_i && grant_i) begin
      if (!auto_eoi_i)     isr_d[win_line_i] = 1'b1;
      else if (rot_aeoi_i) off_d = succ(win_line_i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      isr_q <= '0;
      off_q <= '0;
    end else begin
      isr_q <= isr_d;
      off_q <= off_d;
    end
  end

  assign isr_o    = isr_q;
  assign offset_o = off_q;

  // R5
  ack_sets_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && grant_i && !cmd_valid_i && !auto_eoi_i) |=> isr_q[$past(win_line_i)]);

  // R6
  aeoi_isr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && grant_i && !cmd_valid_i && auto_eoi_i) |=> $stable(isr_q));

  // R7
  eoi_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && (cmd_op_i == OP_EOI_NS || cmd_op_i == OP_EOI_NS_ROT) && isr_q == '0)
    |=> ($stable(isr_q) && $stable(off_q)));

  // R8
  spec_eoi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && cmd_op_i == OP_EOI_SPEC) |=> !isr_q[$past(cmd_line_i)]);

  // R5
  isr_growth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(isr_q) <= $countones($past(isr_q)) + 1));

endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver
  import irq_res_pkg::*;
#(
  parameter int LINES        = 8,
  parameter int CASCADE_LINE = 2,
  parameter int LW           = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] req_i,
  input  logic [LINES-1:0] mask_i,
  input  logic             auto_eoi_i,
  input  logic             rot_aeoi_i,
  input  logic             special_mask_i,
  input  logic             sfnm_i,
  input  logic             master_i,
  input  logic             ack_i,
  input  logic             cmd_valid_i,
  input  logic [2:0]       cmd_op_i,
  input  logic [LW-1:0]    cmd_line_i,
  output logic             int_o,
  output logic             win_valid_o,
  output logic [LW-1:0]    win_line_o,
  output logic [LINES-1:0] isr_o,
  output logic [LW-1:0]    offset_o
);

  logic [LINES-1:0] pend, cur_vec, casc_excl, smm_excl;
  logic [LW:0]      prio_req, prio_cur, prio_top;
  logic             grant;

  assign pend      = req_i & ~mask_i;
  assign smm_excl  = special_mask_i ? mask_i : '0;
  assign casc_excl = (sfnm_i && master_i) ? (LINES'(1) << CASCADE_LINE) : '0;
  assign cur_vec   = isr_o & ~smm_excl & ~casc_excl;

  irq_prio_search #(.LINES(LINES), .LW(LW)) u_req_search (
    .vec_i(pend), .base_i(offset_o), .prio_o(prio_req));

  irq_prio_search #(.LINES(LINES), .LW(LW)) u_cur_search (
    .vec_i(cur_vec), .base_i(offset_o), .prio_o(prio_cur));

  irq_prio_search #(.LINES(LINES), .LW(LW)) u_top_search (
    .vec_i(isr_o), .base_i(offset_o), .prio_o(prio_top));

  assign grant       = (prio_req < prio_cur);
  assign int_o       = grant;
  assign win_valid_o = grant;
  assign win_line_o  = LW'(wrap_add(int'(prio_req[LW-1:0]), int'(offset_o), LINES));

  irq_state_ctrl #(.LINES(LINES), .LW(LW)) u_state (
    .clk(clk), .rst_n(rst_n),
    .ack_i(ack_i), .grant_i(grant), .win_line_i(win_line_o),
    .auto_eoi_i(auto_eoi_i), .rot_aeoi_i(rot_aeoi_i),
    .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i), .cmd_line_i(cmd_line_i),
    .top_prio_i(prio_top),
    .isr_o(isr_o), .offset_o(offset_o));

  // R2
  win_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_o |-> pend[win_line_o]);

  // R2
  no_pend_no_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0) |-> !int_o);

endmodule

// File: tb/irq_prio_resolver_tb.sv
module irq_prio_resolver_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req = '0, mask = '0;
  logic       aeoi = 0, raeoi = 0, smm = 0, sfnm = 0, mstr = 0;
  logic       ack = 0, cmdv = 0;
  logic [2:0] op = '0, cline = '0;
  logic       int_o, win_valid;
  logic [2:0] win_line, offset;
  logic [7:0] isr;

  int checks = 0;
  int errors = 0;

  // model state
  logic [7:0] m_isr;
  logic [2:0] m_off;

  always #5 clk = ~clk;

  irq_prio_resolver u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .mask_i(mask),
    .auto_eoi_i(aeoi), .rot_aeoi_i(raeoi), .special_mask_i(smm),
    .sfnm_i(sfnm), .master_i(mstr), .ack_i(ack), .cmd_valid_i(cmdv),
    .cmd_op_i(op), .cmd_line_i(cline), .int_o(int_o),
    .win_valid_o(win_valid), .win_line_o(win_line), .isr_o(isr),
    .offset_o(offset));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int srch(input logic [7:0] v, input int off);
    for (int p = 0; p < 8; p++) if (v[(p + off) % 8]) return p;
    return 8;
  endfunction

  task automatic do_reset();
    rst_n = 0; ack = 0; cmdv = 0; req = '0; mask = '0;
    aeoi = 0; raeoi = 0; smm = 0; sfnm = 0; mstr = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
  endtask

  task automatic cmd(input logic [2:0] o, input logic [2:0] l);
    @(negedge clk);
    cmdv = 1; op = o; cline = l;
    @(negedge clk);
    cmdv = 0;
    #1;
  endtask

  task automatic ack_once();
    @(negedge clk);
    ack = 1;
    @(negedge clk);
    ack = 0;
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    // R10 reset state
    chk("R10 isr", isr, 0);
    chk("R10 offset", offset, 0);
    chk("R10 int", int_o, 0);
    req = 8'h10; #1;
    chk("R10 int after req", int_o, 1);
    chk("R10 win", win_line, 4);

    // R1 R2 exhaustive offset x request sweep, empty in-service set
    for (int o = 0; o < 8; o++) begin
      req = '0;
      cmd(3'd4, 3'((o + 7) % 8));
      chk("R8 set prio offset", offset, o);
      for (int r = 0; r < 256; r++) begin
        req = 8'(r); #1;
        chk("R2 int sweep", int_o, (r != 0) ? 1 : 0);
        chk("R2 valid sweep", win_valid, (r != 0) ? 1 : 0);
        if (r != 0) chk("R1 win sweep", win_line, (srch(8'(r), o) + o) % 8);
      end
    end

    // R2 mask sweep at offset 0
    do_reset();
    req = 8'hFF;
    for (int mk = 0; mk < 256; mk++) begin
      mask = 8'(mk); #1;
      chk("R2 int mask sweep", int_o, (mk != 255) ? 1 : 0);
      if (mk != 255) chk("R1 win mask sweep", win_line, srch(~8'(mk), 0));
    end
    mask = '0;

    // R3 special mask
    do_reset();
    req = 8'h01; ack_once();
    chk("R5 isr after ack", isr, 8'h01);
    req = 8'h02; #1;
    chk("R2 nested blocked", int_o, 0);
    mask = 8'h01; smm = 1; #1;
    chk("R3 special mask int", int_o, 1);
    chk("R3 special mask win", win_line, 1);
    smm = 0; #1;
    chk("R3 special mask off", int_o, 0);

    // R4 cascade exclusion
    do_reset();
    req = 8'h04; ack_once();
    chk("R5 isr line2", isr, 8'h04);
    #1;
    chk("R4 no sfnm", int_o, 0);
    sfnm = 1; mstr = 1; #1;
    chk("R4 master sfnm int", int_o, 1);
    chk("R4 master sfnm win", win_line, 2);
    mstr = 0; #1;
    chk("R4 slave sfnm", int_o, 0);

    // R7 empty EOI, R9 precedence
    do_reset();
    cmd(3'd4, 3'd4);
    chk("R8 set prio", offset, 5);
    cmd(3'd1, 3'd0);
    chk("R7 empty rot eoi offset", offset, 5);
    chk("R7 empty eoi isr", isr, 0);
    req = 8'h01;
    @(negedge clk);
    ack = 1; cmdv = 1; op = 3'd4; cline = 3'd3;
    @(negedge clk);
    ack = 0; cmdv = 0; #1;
    chk("R9 isr untouched", isr, 0);
    chk("R9 offset", offset, 4);

    // random phase against model
    do_reset();
    m_isr = '0; m_off = '0;
    for (int i = 0; i < 4000; i++) begin
      int pr, pc, ein, ewin;
      logic [7:0] cm;
      @(negedge clk);
      chk("R5 R6 R7 R8 R9 isr", isr, m_isr);
      chk("R6 R7 R8 offset", offset, m_off);
      req   = 8'($urandom);
      mask  = 8'($urandom) & 8'($urandom);
      aeoi  = ($urandom % 4) == 0;
      raeoi = $urandom % 2;
      smm   = ($urandom % 3) == 0;
      sfnm  = $urandom % 2;
      mstr  = $urandom % 2;
      ack   = ($urandom % 2) == 0;
      cmdv  = ($urandom % 4) == 0;
      op    = 3'($urandom);
      cline = 3'($urandom);
      #1;
      pr = srch(req & ~mask, m_off);
      cm = m_isr;
      if (smm) cm = cm & ~mask;
      if (sfnm && mstr) cm[2] = 1'b0;
      pc = srch(cm, m_off);
      ein = (pr < 8 && pr < pc) ? 1 : 0;
      ewin = (pr + m_off) % 8;
      chk("R2 R3 R4 int", int_o, ein);
      chk("R2 valid", win_valid, ein);
      if (ein != 0) chk("R1 win", win_line, ewin);
      if (cmdv) begin
        int tp, tl;
        tp = srch(m_isr, m_off);
        tl = (tp + m_off) % 8;
        case (op)
          3'd0, 3'd1: if (tp < 8) begin
            m_isr[tl] = 1'b0;
            if (op == 3'd1) m_off = 3'((tl + 1) % 8);
          end
          3'd2: m_isr[cline] = 1'b0;
          3'd3: begin m_isr[cline] = 1'b0; m_off = cline + 3'd1; end
          3'd4: m_off = cline + 3'd1;
          default: ;
        endcase
      end else if (ack && ein != 0) begin
        if (!aeoi) m_isr[ewin] = 1'b1;
        else if (raeoi) m_off = 3'((ewin + 1) % 8);
      end
    end
    @(negedge clk);
    ack = 0; cmdv = 0;
    chk("R5 R8 final isr", isr, m_isr);
    chk("R6 R8 final offset", offset, m_off);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule